// File: doc/BRIEF.md
# SMBus Host Notify Status Controller

This block keeps the host notify state of an SMBus target-side controller. When the byte engine reports a complete, successful Host Notify message, the block captures the sender address and the 16-bit data word and sets a sticky status flag. While that flag is high, the block tells the byte engine to refuse new notify messages and keeps the captured address and data unchanged. Software clears the flag by writing 1 to it.

From the status flag and three control bits, the block builds three requests. The interrupt request goes to either an interrupt line or an SMI line, as chosen by a routing input. A wake pulse follows an accepted notify. An alert request is the incoming alert status masked by a disable bit.

The registers live in a slow clock domain. Software writes them from a fast bus clock through a toggle request/acknowledge handshake. A busy flag shows when a write is still in flight.

Top module: `hn_status_ctl`

## Requirements
- R1: The status flag (status register bit 0) goes from 0 to 1 only in the slow cycle after `hn_done` is sampled high while the flag is 0.
- R2: Writing the status register (`wr_sel`=0) with data bit 0 = 1 clears the flag. With data bit 0 = 0 the flag does not change. If a clear and an accepted notify fall in the same slow cycle, the flag ends up set.
- R3: `hn_nack` is high exactly while the status flag is 1.
- R4: `notify_addr` and `notify_data` take the `hn_addr` and `hn_data` values only when a notify is accepted, that is, when the flag was 0. At all other times they hold their value.
- R5: The request is status AND interrupt enable (control bit 0). Setting the enable while the flag is already 1 raises the request as soon as the write completes.
- R6: The interrupt enable has no effect on whether an accepted notify sets the flag.
- R7: With `route_smi`=0 the request appears on `irq_req` and `smi_req` stays low. With `route_smi`=1 it appears on `smi_req` only.
- R8: `alert_req` equals `alert_in` AND NOT the alert-disable bit (control bit 2).
- R9: When a notify is accepted while wake enable (control bit 1) is 1, `wake_req` is high for exactly one slow cycle: the cycle in which the flag becomes 1.
- R10: `busy` rises in the bus cycle after an accepted write and stays high until the slow-domain update is acknowledged. A `wr_en` pulse seen while `busy` is high is dropped.
- R11: All state resets to 0. Reserved bits (status bits 7:1, control bits 7:3) read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | fast software bus clock |
| rst_bus_n | input | 1 | active-low reset, bus domain |
| clk_slow | input | 1 | slow register clock |
| rst_slow_n | input | 1 | active-low reset, slow domain |
| wr_en | input | 1 | one-cycle write strobe |
| wr_sel | input | 1 | 0 = status register, 1 = control register |
| wr_data | input | 8 | write data |
| busy | output | 1 | write in flight |
| rd_status | output | 8 | status register read value |
| rd_ctrl | output | 8 | control register read value |
| hn_done | input | 1 | complete notify received (slow domain) |
| hn_addr | input | 7 | sender address of the message |
| hn_data | input | 16 | data word of the message |
| hn_nack | output | 1 | refuse first byte of new notify |
| notify_addr | output | 7 | captured sender address |
| notify_data | output | 16 | captured data word |
| route_smi | input | 1 | steer request to SMI instead of interrupt |
| alert_in | input | 1 | incoming alert status |
| irq_req | output | 1 | interrupt request |
| smi_req | output | 1 | SMI request |
| wake_req | output | 1 | wake event pulse |
| alert_req | output | 1 | masked alert request |

## Verification
The assertions assume that `hn_done` is a single slow-cycle pulse, that `hn_addr` and `hn_data` are valid while it is high, and that `wr_sel` and `wr_data` are held only during the strobe cycle. The bench drives notify inputs on slow-clock falling edges and bus inputs on bus falling edges, so the inputs are stable around each capturing edge. It drops a `wr_en` strobe only while `busy` is high, which is the behaviour R10 defines. Reads are taken only after `busy` falls, so the slow-domain values the bench samples are settled.

// File: rtl/hn_status_ctl.sv
module hn_status_ctl #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk_bus,
  input  logic              rst_bus_n,
  input  logic              clk_slow,
  input  logic              rst_slow_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [7:0]        wr_data,
  output logic              busy,
  output logic [7:0]        rd_status,
  output logic [7:0]        rd_ctrl,
  input  logic              hn_done,
  input  logic [ADDR_W-1:0] hn_addr,
  input  logic [DATA_W-1:0] hn_data,
  output logic              hn_nack,
  output logic [ADDR_W-1:0] notify_addr,
  output logic [DATA_W-1:0] notify_data,
  input  logic              route_smi,
  input  logic              alert_in,
  output logic              irq_req,
  output logic              smi_req,
  output logic              wake_req,
  output logic              alert_req
);
  localparam int CTRL_W = 3;

  // bus domain
  logic              req_tgl;
  logic              hold_sel;
  logic [CTRL_W-1:0] hold_data;
  logic [SYNC_N-1:0] ack_sync;

  always_ff @(posedge clk_bus or negedge rst_bus_n)
    if (!rst_bus_n) begin
      req_tgl   <= 1'b0;
      hold_sel  <= 1'b0;
      hold_data <= '0;
    end else if (wr_en && !busy) begin
      req_tgl   <= ~req_tgl;
      hold_sel  <= wr_sel;
      hold_data <= wr_data[CTRL_W-1:0];
    end

  // slow domain
  logic [SYNC_N-1:0] req_sync;
  logic              req_seen;
  logic              ack_tgl;
  logic              sts_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              wake_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_bus or negedge rst_bus_n)
    if (!rst_bus_n) ack_sync <= '0;
    else            ack_sync <= {ack_sync[SYNC_N-2:0], ack_tgl};

  assign busy = req_tgl ^ ack_sync[SYNC_N-1];

  always_ff @(posedge clk_slow or negedge rst_slow_n)
    if (!rst_slow_n) req_sync <= '0;
    else             req_sync <= {req_sync[SYNC_N-2:0], req_tgl};

  wire apply   = req_sync[SYNC_N-1] ^ req_seen;
  wire clr_sts = apply && !hold_sel && hold_data[0];
  wire accept  = hn_done && !sts_q;

  always_ff @(posedge clk_slow or negedge rst_slow_n)
    if (!rst_slow_n) begin
      req_seen <= 1'b0;
      ack_tgl  <= 1'b0;
      sts_q    <= 1'b0;
      ctrl_q   <= '0;
      wake_q   <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      req_seen <= req_sync[SYNC_N-1];
      ack_tgl  <= req_sync[SYNC_N-1];
      sts_q    <= accept | (sts_q & ~clr_sts);
      wake_q   <= accept & ctrl_q[1];
      if (apply && hold_sel) ctrl_q <= hold_data;
      if (accept) begin
        addr_q <= hn_addr;
        data_q <= hn_data;
      end
    end

  wire req = sts_q & ctrl_q[0];

  assign rd_status   = {7'b0, sts_q};
  assign rd_ctrl     = {{(8-CTRL_W){1'b0}}, ctrl_q};
  assign hn_nack     = sts_q;
  assign notify_addr = addr_q;
  assign notify_data = data_q;
  assign irq_req     = req & ~route_smi;
  assign smi_req     = req & route_smi;
  assign wake_req    = wake_q;
  assign alert_req   = alert_in & ~ctrl_q[2];
endmodule

module hn_status_ctl_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input logic              clk_bus,
  input logic              rst_bus_n,
  input logic              clk_slow,
  input logic              rst_slow_n,
  input logic              wr_en,
  input logic              busy,
  input logic [7:0]        rd_status,
  input logic [7:0]        rd_ctrl,
  input logic              hn_done,
  input logic              hn_nack,
  input logic [ADDR_W-1:0] notify_addr,
  input logic [DATA_W-1:0] notify_data,
  input logic              irq_req,
  input logic              smi_req,
  input logic              wake_req,
  input logic              alert_req,
  input logic              alert_in
);
  p_set_on_done_r1: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
    hn_done && !rd_status[0] |=> rd_status[0]);
  p_rise_cause_r1: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
    $rose(rd_status[0]) |-> $past(hn_done));
  p_hold_capture_r4: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
    rd_status[0] |=> $stable(notify_addr) && $stable(notify_data));
  p_req_needs_sts_r5: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
    (irq_req || smi_req) |-> rd_status[0] && rd_ctrl[0] && hn_nack);
  p_one_route_r7: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
    $onehot0({irq_req, smi_req}));
  p_alert_mask_r8: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
    alert_req |-> alert_in && !rd_ctrl[2]);
  p_wake_cause_r9: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
    wake_req |-> $rose(rd_status[0]) && $past(rd_ctrl[1]));
  p_busy_rise_r10: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    wr_en && !busy |=> busy);
  p_reserved_r11: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
    rd_status[7:1] == 7'd0 && rd_ctrl[7:3] == 5'd0);
endmodule

bind hn_status_ctl hn_status_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_hn_status_ctl.sv
module tb_hn_status_ctl;
  logic clk = 0, clk_slow = 0, rst_n = 0;
  logic wr_en = 0, wr_sel = 0, hn_done = 0, route_smi = 0, alert_in = 0;
  logic [7:0] wr_data = 0;
  logic [6:0] hn_addr = 0;
  logic [15:0] hn_data = 0;
  logic busy, hn_nack, irq_req, smi_req, wake_req, alert_req;
  logic [7:0] rd_status, rd_ctrl;
  logic [6:0] notify_addr;
  logic [15:0] notify_data;

  hn_status_ctl dut (
    .clk_bus(clk), .rst_bus_n(rst_n), .clk_slow(clk_slow), .rst_slow_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .busy(busy),
    .rd_status(rd_status), .rd_ctrl(rd_ctrl), .hn_done(hn_done),
    .hn_addr(hn_addr), .hn_data(hn_data), .hn_nack(hn_nack),
    .notify_addr(notify_addr), .notify_data(notify_data),
    .route_smi(route_smi), .alert_in(alert_in), .irq_req(irq_req),
    .smi_req(smi_req), .wake_req(wake_req), .alert_req(alert_req));

  always #4 clk = ~clk;
  always #44 clk_slow = ~clk_slow;

  int checks = 0, fails = 0;
  logic m_sts = 0;
  logic [2:0] m_ctrl = 0;
  logic [6:0] m_addr = 0;
  logic [15:0] m_data = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic f_req(); return m_sts & m_ctrl[0]; endfunction

  task automatic check_all();
    chk("R1/R2 status", rd_status, {7'b0, m_sts});
    chk("R11 ctrl", rd_ctrl, {5'b0, m_ctrl});
    chk("R3 nack", hn_nack, m_sts);
    chk("R4 addr", notify_addr, m_addr);
    chk("R4 data", notify_data, m_data);
    chk("R5/R7 irq", irq_req, f_req() & ~route_smi);
    chk("R5/R7 smi", smi_req, f_req() & route_smi);
    chk("R8 alert", alert_req, alert_in & ~m_ctrl[2]);
  endtask

  task automatic bus_write(input logic sel, input logic [7:0] d);
    while (busy) @(negedge clk);
    wr_sel = sel; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    chk("R10 busy after write", busy, 1);
    while (busy) @(negedge clk);
    if (!sel && d[0]) m_sts = 0;
    if (sel) m_ctrl = d[2:0];
    @(negedge clk);
  endtask

  task automatic notify(input logic [6:0] a, input logic [15:0] d);
    logic acc;
    @(negedge clk_slow);
    hn_addr = a; hn_data = d; hn_done = 1;
    @(negedge clk_slow);
    hn_done = 0;
    acc = !m_sts;
    chk("R9 wake pulse", wake_req, acc & m_ctrl[1]);
    if (acc) begin m_sts = 1; m_addr = a; m_data = d; end
    @(negedge clk_slow);
    chk("R9 wake one cycle", wake_req, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (6) @(negedge clk_slow);
    rst_n = 1;
    @(negedge clk);
    check_all();  // R11 reset state
    chk("R10 busy reset", busy, 0);

    // R6: enable off, notify still sets
    notify(7'h12, 16'hbeef); check_all();
    // R4: second notify ignored while set
    notify(7'h33, 16'h1234); check_all();
    // R5: enable while set raises request
    bus_write(1, 8'h01); check_all();
    route_smi = 1; @(negedge clk); check_all();  // R7
    route_smi = 0;
    // R2: write 0 no effect, reserved bits ignored
    bus_write(0, 8'hfe); check_all();
    bus_write(0, 8'h01); check_all();
    // R11 reserved ctrl bits
    bus_write(1, 8'hfa); check_all();
    alert_in = 1; @(negedge clk); check_all();  // R8
    bus_write(1, 8'h02); check_all();
    // R9: wake enabled notify
    notify(7'h55, 16'h00aa); check_all();
    // R10: write while busy dropped
    while (busy) @(negedge clk);
    wr_sel = 1; wr_data = 8'h05; wr_en = 1; @(negedge clk);
    wr_data = 8'h02; @(negedge clk); wr_en = 0;
    while (busy) @(negedge clk);
    m_ctrl = 3'h5; @(negedge clk);
    chk("R10 dropped write", rd_ctrl, 8'h05);

    for (int i = 0; i < 60; i++) begin
      case ($urandom % 4)
        0: bus_write(0, 8'($urandom));
        1: bus_write(1, 8'($urandom));
        2: notify(7'($urandom), 16'($urandom));
        default: begin route_smi = 1'($urandom); alert_in = 1'($urandom); @(negedge clk); end
      endcase
      check_all();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule